// File: doc/BRIEF.md
# Serial Configuration Loader with Latch Routing

This block receives configuration words over a three-wire serial link: a serial clock, a data line and a load strobe. Every rising edge of the serial clock shifts one data bit into a 21-bit shift register, most significant bit first. A rising edge on the load strobe copies the word into one of four configuration latches. The two lowest bits of the word select the latch.

The three serial inputs are asynchronous to the system clock. Each one passes through a two-stage synchroniser, and its edges are detected in the system clock domain. The latches drive field outputs to neighbouring logic: a 14-bit reference divide value, a 5-bit A value, a 13-bit B value, the function payload and the initialization payload.

The lowest three bits of the function payload control an output multiplexer. The multiplexer routes one of four observation sources to a single pin: a lock flag, a reference tick, a feedback tick, or the most significant bit of the shift register.

Top module: `serial_cfg_loader`

## Requirements
- R1: While `rst_n` is low, and until the first load after reset, `ref_div`, `a_val`, `b_val`, `func_word` and `init_word` read zero and `mux_out` is low.
- R2: Each rising edge of `ser_clk` shifts the sampled `ser_data` into bit 0 of a 21-bit shift register, moving the older bits up by one. When more than 21 bits are sent, only the last 21 are kept, so the first bit sent ends up as bit 20 (MSB first).
- R3: A rising edge of `ser_load` when word bits [1:0] = 00 loads `ref_div` with word bits [15:2] and leaves every other latch unchanged.
- R4: A rising edge of `ser_load` when word bits [1:0] = 01 loads `a_val` with word bits [6:2] and `b_val` with word bits [19:7], and leaves the other latches unchanged.
- R5: A rising edge of `ser_load` when word bits [1:0] = 10 loads `func_word` with word bits [20:2], and leaves the other latches unchanged.
- R6: A rising edge of `ser_load` when word bits [1:0] = 11 loads both `init_word` and `func_word` with word bits [20:2].
- R7: `mux_out` follows a source chosen by `func_word[2:0]`: code 001 gives `lock_in`, 010 gives `ref_tick`, 011 gives `fb_tick`, and 100 gives bit 20 of the shift register.
- R8: The select codes 000, 101, 110 and 111 hold `mux_out` low, whatever the source inputs are.
- R9: Serial clock edges without a load edge never change any latch output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial shift clock, asynchronous |
| ser_data | input | 1 | Serial data, MSB first |
| ser_load | input | 1 | Load strobe; a rising edge commits the word |
| lock_in | input | 1 | Lock flag source for the multiplexer |
| ref_tick | input | 1 | Reference divider tick source |
| fb_tick | input | 1 | Feedback divider tick source |
| ref_div | output | 14 | Reference divide latch |
| a_val | output | 5 | A field of the feedback latch |
| b_val | output | 13 | B field of the feedback latch |
| func_word | output | 19 | Function latch payload |
| init_word | output | 19 | Initialization latch payload |
| mux_out | output | 1 | Multiplexer output |

## Verification
The assertions assume that the serial clock and the load strobe never produce an edge in the same system clock cycle. They also assume that each serial input level lasts long enough to pass through the synchroniser, so that every edge is seen exactly once. The stimulus changes data only while the serial clock is low. It holds each serial level for three system clocks and separates the load pulse from the last shift edge by several cycles. Random words with random control bits are mixed with directed cases: over-long shifts, shifts with no load, and every multiplexer code.

// File: rtl/serial_cfg_loader.sv
module serial_cfg_loader #(
  parameter int WORD_W = 21,
  parameter int REF_W  = 14,
  parameter int A_W    = 5,
  parameter int B_W    = 13,
  parameter int SEL_W  = 3,
  parameter int SYNC   = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ser_clk,
  input  logic                 ser_data,
  input  logic                 ser_load,
  input  logic                 lock_in,
  input  logic                 ref_tick,
  input  logic                 fb_tick,
  output logic [REF_W-1:0]     ref_div,
  output logic [A_W-1:0]       a_val,
  output logic [B_W-1:0]       b_val,
  output logic [WORD_W-3:0]    func_word,
  output logic [WORD_W-3:0]    init_word,
  output logic                 mux_out
);
  localparam int CTL_W = 2;
  localparam int PAY_W = WORD_W - CTL_W;
  localparam int A_LO  = CTL_W;
  localparam int B_LO  = CTL_W + A_W;

  logic [SYNC:0]       sclk_q, sdat_q, sld_q;
  logic [WORD_W-1:0]   shreg;
  logic                sclk_rise, ld_rise, sdata_s;
  logic [CTL_W-1:0]    ctl;
  logic [SEL_W-1:0]    sel;

  assign sclk_rise = sclk_q[SYNC-1] & ~sclk_q[SYNC];
  assign ld_rise   = sld_q[SYNC-1] & ~sld_q[SYNC];
  assign sdata_s   = sdat_q[SYNC-1];
  assign ctl       = shreg[CTL_W-1:0];
  assign sel       = func_word[SEL_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= '0;
      sdat_q <= '0;
      sld_q  <= '0;
    end else begin
      sclk_q <= {sclk_q[SYNC-1:0], ser_clk};
      sdat_q <= {sdat_q[SYNC-1:0], ser_data};
      sld_q  <= {sld_q[SYNC-1:0], ser_load};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         shreg <= '0;
    else if (sclk_rise) shreg <= {shreg[WORD_W-2:0], sdata_s};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_div   <= '0;
      a_val     <= '0;
      b_val     <= '0;
      func_word <= '0;
      init_word <= '0;
    end else if (ld_rise) begin
      case (ctl)
        2'b00: ref_div <= shreg[CTL_W+REF_W-1:CTL_W];
        2'b01: begin
          a_val <= shreg[A_LO+A_W-1:A_LO];
          b_val <= shreg[B_LO+B_W-1:B_LO];
        end
        2'b10: func_word <= shreg[WORD_W-1:CTL_W];
        default: begin
          func_word <= shreg[WORD_W-1:CTL_W];
          init_word <= shreg[WORD_W-1:CTL_W];
        end
      endcase
    end
  end

  always_comb begin
    case (sel)
      3'd1:    mux_out = lock_in;
      3'd2:    mux_out = ref_tick;
      3'd3:    mux_out = fb_tick;
      3'd4:    mux_out = shreg[WORD_W-1];
      default: mux_out = 1'b0;
    endcase
  end

  logic unused_pay;
  assign unused_pay = ^PAY_W;
endmodule

module serial_cfg_loader_chk #(
  parameter int WORD_W = 21,
  parameter int REF_W  = 14,
  parameter int A_W    = 5,
  parameter int B_W    = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sclk_rise,
  input logic              ld_rise,
  input logic              sdata_s,
  input logic [WORD_W-1:0] shreg,
  input logic [REF_W-1:0]  ref_div,
  input logic [A_W-1:0]    a_val,
  input logic [B_W-1:0]    b_val,
  input logic [WORD_W-3:0] func_word,
  input logic [WORD_W-3:0] init_word,
  input logic              mux_out
);
  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (ref_div == '0 && a_val == '0 && b_val == '0 && func_word == '0 && init_word == '0)); // R1
  AST_SHIFT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_rise |=> shreg == {$past(shreg[WORD_W-2:0]), $past(sdata_s)}); // R2
  AST_REF_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_rise && shreg[1:0] == 2'b00) |=> (ref_div == $past(shreg[REF_W+1:2]) && $stable(func_word) && $stable(a_val))); // R3
  AST_N_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_rise && shreg[1:0] == 2'b01) |=> (a_val == $past(shreg[A_W+1:2]) && b_val == $past(shreg[A_W+B_W+1:A_W+2]) && $stable(ref_div))); // R4
  AST_FUNC_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_rise && shreg[1:0] == 2'b10) |=> (func_word == $past(shreg[WORD_W-1:2]) && $stable(init_word))); // R5
  AST_INIT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_rise && shreg[1:0] == 2'b11) |=> (init_word == $past(shreg[WORD_W-1:2]) && func_word == init_word)); // R6
  AST_MUX_SHIFT_MSB: assert property (@(posedge clk) disable iff (!rst_n)
    (func_word[2:0] == 3'd4) |-> mux_out == shreg[WORD_W-1]); // R7
  AST_MUX_UNUSED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (func_word[2:0] == 3'd0 || func_word[2:0] >= 3'd5) |-> !mux_out); // R8
  AST_HOLD_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_rise |=> $stable({ref_div, a_val, b_val, func_word, init_word})); // R9
endmodule

bind serial_cfg_loader serial_cfg_loader_chk #(
  .WORD_W(WORD_W), .REF_W(REF_W), .A_W(A_W), .B_W(B_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sclk_rise(sclk_rise), .ld_rise(ld_rise),
  .sdata_s(sdata_s), .shreg(shreg), .ref_div(ref_div), .a_val(a_val),
  .b_val(b_val), .func_word(func_word), .init_word(init_word), .mux_out(mux_out)
);

// File: tb/serial_cfg_loader_bench.sv
module serial_cfg_loader_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_data = 1'b0, ser_load = 1'b0;
  logic lock_in = 1'b0, ref_tick = 1'b0, fb_tick = 1'b0;
  logic [13:0] ref_div;
  logic [4:0]  a_val;
  logic [12:0] b_val;
  logic [18:0] func_word, init_word;
  logic mux_out;

  int total = 0, bad = 0;
  bit done = 0;
  logic [13:0] e_ref;
  logic [4:0]  e_a;
  logic [12:0] e_b;
  logic [18:0] e_func, e_init;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_cfg_loader u_serial_cfg_loader (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
    .ser_load(ser_load), .lock_in(lock_in), .ref_tick(ref_tick), .fb_tick(fb_tick),
    .ref_div(ref_div), .a_val(a_val), .b_val(b_val), .func_word(func_word),
    .init_word(init_word), .mux_out(mux_out)
  );

  function automatic logic exp_mux(input logic [2:0] sel, input logic lk,
                                   input logic rt, input logic ft, input logic msb);
    case (sel)
      3'd1: return lk;
      3'd2: return rt;
      3'd3: return ft;
      3'd4: return msb;
      default: return 1'b0;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0h expected=%0h", req, got, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic send_bit(input logic b);
    ser_data = b;
    wait_clk(3);
    ser_clk = 1'b1;
    wait_clk(3);
    ser_clk = 1'b0;
    wait_clk(3);
  endtask

  task automatic send_word(input logic [20:0] w);
    for (int i = 20; i >= 0; i--) send_bit(w[i]);
  endtask

  task automatic pulse_load();
    ser_load = 1'b1;
    wait_clk(4);
    ser_load = 1'b0;
    wait_clk(4);
    @(negedge clk);
  endtask

  task automatic model_load(input logic [20:0] w);
    case (w[1:0])
      2'b00: e_ref = w[15:2];
      2'b01: begin e_a = w[6:2]; e_b = w[19:7]; end
      2'b10: e_func = w[20:2];
      default: begin e_func = w[20:2]; e_init = w[20:2]; end
    endcase
  endtask

  task automatic check_all(input string req);
    check({req, " ref_div"}, 32'(ref_div), 32'(e_ref));
    check({req, " a_val"}, 32'(a_val), 32'(e_a));
    check({req, " b_val"}, 32'(b_val), 32'(e_b));
    check({req, " func_word"}, 32'(func_word), 32'(e_func));
    check({req, " init_word"}, 32'(init_word), 32'(e_init));
  endtask

  task automatic load_word(input logic [20:0] w, input string req);
    send_word(w);
    pulse_load();
    model_load(w);
    check_all(req);
  endtask

  initial begin
    logic [20:0] w;
    logic [1:0] sb;
    logic msb;
    void'($urandom(32'h5EED_0421));
    e_ref = '0; e_a = '0; e_b = '0; e_func = '0; e_init = '0;
    wait_clk(5);
    @(negedge clk);
    check_all("R1 in reset");
    check("R1 mux in reset", 32'(mux_out), 32'd0);
    rst_n = 1'b1;
    wait_clk(3);
    @(negedge clk);
    check_all("R1 after reset");

    load_word(21'h0AAAA8, "R3 directed");
    load_word({8'h00, 13'h1ABC, 5'h15, 2'b01}, "R4 directed");
    load_word({19'h7FFFF, 2'b10}, "R5 directed");
    load_word({19'h2A5A4, 2'b11}, "R6 directed");

    for (int k = 0; k < 4; k++) send_bit(1'b1);
    w = 21'h12345 << 2;
    send_word(w | 21'd2);
    pulse_load();
    model_load(w | 21'd2);
    check_all("R2 overlong shift");

    for (int k = 0; k < 40; k++) begin
      w = 21'($urandom);
      load_word(w, "R3/R4/R5/R6 random");
      for (int j = 0; j < 5; j++) send_bit(1'($urandom));
      @(negedge clk);
      check_all("R9 shift without load");
    end

    for (int code = 0; code < 8; code++) begin
      w = {16'($urandom), 3'(code), 2'b10};
      load_word(w, "R5 select load");
      msb = w[20];
      for (int j = 0; j < 4; j++) begin
        lock_in = 1'($urandom); ref_tick = 1'($urandom); fb_tick = 1'($urandom);
        @(negedge clk);
        check((code == 0 || code > 4) ? "R8 unused code" : "R7 mux source",
              32'(mux_out), 32'(exp_mux(3'(code), lock_in, ref_tick, fb_tick, msb)));
      end
      if (code == 4) begin
        sb = 2'($urandom);
        send_bit(sb[0]);
        @(negedge clk);
        check("R7 shift msb after one bit", 32'(mux_out), 32'(w[19]));
        check("R2 msb moves up", 32'(mux_out), 32'(w[19]));
      end
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait_clk(150000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog got=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule